// File: doc/BRIEF.md
# Predictive resonant switching period calculator

A boost power-factor stage that runs in discontinuous mode rings after its inductor current reaches zero. This block predicts when that ring brings the current back up from negative to zero. It returns the switching period Ts that places the next turn-on at that instant, together with the position of the ADC sample trigger that follows from Ts. The prediction comes from a volt-second balance. There are two forms: one for input voltages below half the bus voltage, where the switch node reaches zero volts, and one at or above half, where it reaches only a valley.

Control firmware or a loop sequencer pulses `start` once per switching cycle. Each accepted start captures the rectified input voltage, the raw bus voltage, the current-loop duty command, the nominal period, the resonant period and the trigger offset. It also advances an internal duty smoothing filter. A registered datapath then forms the on-time, the numerator and the divisor, and runs a one-bit-per-cycle integer divider. Ts and the trigger appear together with a one-cycle `done` pulse. When prediction is switched off, the block passes the nominal period through and places the trigger relative to it.

Top module: `pfc_resonant_period`

## Requirements
- R1: After reset, ts_out and trig_out are 0 and done and busy are low.
- R2: An internal filter value y starts at 0 after reset. Each accepted start updates it as y := y + duty − (y >> 2), and the computation that this start launches uses the updated y.
- R3: The on-time is ton = ((y >> 8) · (t_nom >> 4)) >> 13, saturated to 16 bits.
- R4: The rescaled bus voltage is vo = (vbus · 40000) >> 15, saturated to 4095. The difference dv = vo − vin becomes 0 when vin ≥ vo.
- R5: With prediction on and vin < (vo >> 1), the mode is zero-voltage. In that mode, Ts = sat16( (8·vc·ton·vo + t_res·vo·dv) / (8·vc·dv) ) + (t_res >> 2), and the sum saturates at 65535.
- R6: In the zero-voltage mode, vc = max(vin, vin_min). The clamp applies only to vc; dv uses the unclamped vin.
- R7: With prediction on and vin ≥ (vo >> 1), the mode is valley: Ts = sat16(ton·vo / dv) + (t_res >> 1), and the sum saturates at 65535.
- R8: A zero divisor in either mode forces Ts = 65535.
- R9: trig_out = max(Ts − 4·trig_ofs, 0). With pred_en low, Ts is t_nom.
- R10: done is a one-cycle pulse exactly 46 clock cycles after the edge that accepts start. ts_out and trig_out change only together with done.
- R11: A start that arrives while busy is high is ignored. It captures no inputs, does not advance the filter and produces no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one prediction (accepted when idle) |
| pred_en | input | 1 | 1: predicted period, 0: nominal period |
| vin | input | 12 | Rectified instantaneous input voltage |
| vbus | input | 12 | Raw output bus voltage sample |
| vin_min | input | 12 | Lower clamp for vin in zero-voltage mode |
| duty | input | 16 | Current-loop duty command |
| t_nom | input | 16 | Nominal switching period |
| t_res | input | 16 | Resonant period constant |
| trig_ofs | input | 8 | Sample-trigger offset, applied times four |
| ts_out | output | 16 | Predicted switching period |
| trig_out | output | 16 | ADC sample-trigger position |
| done | output | 1 | Result valid pulse |
| busy | output | 1 | Computation in progress |

## Verification
The hardest condition to reach from the ports is a start that arrives while a computation is in flight. Its effect would show only as a corrupted filter state in a later result. The stimulus pulses a second start with different inputs in the middle of a computation. It confirms that the first result is unchanged and that only one done occurs. The following computation is then scored against a filter model that never saw the second start. A second hard corner is the pair of zero-divisor paths, one per mode. They are reached in valley mode by an input above the rescaled bus and in zero-voltage mode by a zero input with a zero clamp. Both sides of the half-bus boundary are driven at an exact even bus value.

// File: rtl/pfc_period_pkg.sv
package pfc_period_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_DIV  = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pfc_duty_filter.sv
module pfc_duty_filter #(
  parameter int DW = 16,
  parameter int FW = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [DW-1:0] duty_in,
  output logic [FW-1:0] y_out
);
  function automatic logic [FW-1:0] leak_step(input logic [FW-1:0] y,
                                              input logic [DW-1:0] x);
    return y + FW'(x) - (y >> 2);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_out <= '0;
    else if (upd) y_out <= leak_step(y_out, duty_in);
  end
endmodule

// File: rtl/pfc_period_prep.sv
module pfc_period_prep #(
  parameter int VW       = 12,
  parameter int DW       = 16,
  parameter int FW       = DW + 2,
  parameter int PW       = 16,
  parameter int BUS_K    = 40000,
  parameter int BUS_SHR  = 15,
  parameter int DUTY_SHR = 8,
  parameter int PER_SHR  = 4,
  parameter int TON_SHR  = 13,
  parameter int NW       = 3 + 2*VW + PW + 1,
  parameter int DENW     = 3 + 2*VW
) (
  input  logic [VW-1:0]   vin,
  input  logic [VW-1:0]   vbus,
  input  logic [VW-1:0]   vin_min,
  input  logic [FW-1:0]   y_filt,
  input  logic [PW-1:0]   t_nom,
  input  logic [PW-1:0]   t_res,
  output logic [NW-1:0]   num,
  output logic [DENW-1:0] den,
  output logic [PW-1:0]   add_term,
  output logic            dcm_mode,
  output logic            den_zero
);
  localparam int PRW = FW + PW;
  localparam int KW  = 16;
  localparam int BW  = VW + KW;

  function automatic logic [PW-1:0] on_time(input logic [FW-1:0] y,
                                            input logic [PW-1:0] per);
    logic [PRW-1:0] prod;
    prod = (PRW'(y >> DUTY_SHR) * PRW'(per >> PER_SHR)) >> TON_SHR;
    return (prod > PRW'({PW{1'b1}})) ? {PW{1'b1}} : prod[PW-1:0];
  endfunction

  function automatic logic [VW-1:0] bus_rescale(input logic [VW-1:0] vb);
    logic [BW-1:0] p;
    p = (BW'(vb) * BW'(BUS_K)) >> BUS_SHR;
    return (p > BW'({VW{1'b1}})) ? {VW{1'b1}} : p[VW-1:0];
  endfunction

  logic [PW-1:0] ton;
  logic [VW-1:0] vo, dv, vc;

  always_comb begin
    ton      = on_time(y_filt, t_nom);
    vo       = bus_rescale(vbus);
    dv       = (vo > vin) ? vo - vin : '0;
    dcm_mode = vin < (vo >> 1);
    vc       = (dcm_mode && (vin < vin_min)) ? vin_min : vin;
    if (dcm_mode) begin
      num      = ((NW'(vc) * NW'(ton) * NW'(vo)) << 3) + NW'(t_res) * NW'(vo) * NW'(dv);
      den      = (DENW'(vc) * DENW'(dv)) << 3;
      add_term = t_res >> 2;
    end else begin
      num      = NW'(ton) * NW'(vo);
      den      = DENW'(dv);
      add_term = t_res >> 1;
    end
    den_zero = (den == '0);
  end
endmodule

// File: rtl/pfc_seq_divider.sv
module pfc_seq_divider #(
  parameter int NW   = 44,
  parameter int DENW = 27
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NW-1:0]   num_in,
  input  logic [DENW-1:0] den_in,
  output logic [NW-1:0]   quo_out,
  output logic            last_out
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0]   q;
  logic [DENW:0]   rem, rem_sh, trial;
  logic [DENW-1:0] den_q;
  logic [CW-1:0]   cnt;
  logic            ge;

  always_comb begin
    rem_sh = {rem[DENW-1:0], q[NW-1]};
    ge     = rem_sh >= {1'b0, den_q};
    trial  = rem_sh - {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      q     <= num_in;
      rem   <= '0;
      den_q <= den_in;
      cnt   <= CW'(NW);
    end else if (cnt != '0) begin
      rem <= ge ? trial : rem_sh;
      q   <= {q[NW-2:0], ge};
      cnt <= cnt - 1'b1;
    end
  end

  assign quo_out  = q;
  assign last_out = (cnt == CW'(1));
endmodule

// File: rtl/pfc_resonant_period.sv
module pfc_resonant_period #(
  parameter int VW       = 12,
  parameter int DW       = 16,
  parameter int PW       = 16,
  parameter int OFW      = 8,
  parameter int BUS_K    = 40000,
  parameter int BUS_SHR  = 15,
  parameter int DUTY_SHR = 8,
  parameter int PER_SHR  = 4,
  parameter int TON_SHR  = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           pred_en,
  input  logic [VW-1:0]  vin,
  input  logic [VW-1:0]  vbus,
  input  logic [VW-1:0]  vin_min,
  input  logic [DW-1:0]  duty,
  input  logic [PW-1:0]  t_nom,
  input  logic [PW-1:0]  t_res,
  input  logic [OFW-1:0] trig_ofs,
  output logic [PW-1:0]  ts_out,
  output logic [PW-1:0]  trig_out,
  output logic           done,
  output logic           busy
);
  import pfc_period_pkg::*;

  localparam int FW   = DW + 2;
  localparam int NW   = 3 + 2*VW + PW + 1;
  localparam int DENW = 3 + 2*VW;

  seq_state_e state;

  logic [VW-1:0]  vin_q, vbus_q, vmin_q;
  logic [PW-1:0]  tnom_q, tres_q, add_q;
  logic [OFW-1:0] ofs_q;
  logic           en_q, zero_q;

  logic [FW-1:0]   y_filt;
  logic [NW-1:0]   num_w, quo_w;
  logic [DENW-1:0] den_w;
  logic [PW-1:0]   add_w, ts_w, trig_w;
  logic            dcm_w, den_zero_w, div_last;

  // named internal events for the checker
  logic accept_w, fin_w, div_zero_w;
  assign accept_w   = start && (state == ST_IDLE);
  assign fin_w      = (state == ST_FIN);
  assign div_zero_w = zero_q;
  assign busy       = (state != ST_IDLE);

  function automatic logic [PW-1:0] narrow_sat(input logic [NW-1:0] v);
    return (v > NW'({PW{1'b1}})) ? {PW{1'b1}} : v[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] add_sat(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PW] ? {PW{1'b1}} : s[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] sub_floor(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return (a >= b) ? a - b : '0;
  endfunction

  pfc_duty_filter #(.DW(DW), .FW(FW)) i_filt (
    .clk(clk), .rst_n(rst_n), .upd(accept_w), .duty_in(duty), .y_out(y_filt)
  );

  pfc_period_prep #(
    .VW(VW), .DW(DW), .FW(FW), .PW(PW), .BUS_K(BUS_K), .BUS_SHR(BUS_SHR),
    .DUTY_SHR(DUTY_SHR), .PER_SHR(PER_SHR), .TON_SHR(TON_SHR), .NW(NW), .DENW(DENW)
  ) i_prep (
    .vin(vin_q), .vbus(vbus_q), .vin_min(vmin_q), .y_filt(y_filt),
    .t_nom(tnom_q), .t_res(tres_q), .num(num_w), .den(den_w),
    .add_term(add_w), .dcm_mode(dcm_w), .den_zero(den_zero_w)
  );

  pfc_seq_divider #(.NW(NW), .DENW(DENW)) i_div (
    .clk(clk), .rst_n(rst_n), .load(state == ST_PREP),
    .num_in(num_w), .den_in(den_w), .quo_out(quo_w), .last_out(div_last)
  );

  always_comb begin
    if (!en_q)       ts_w = tnom_q;
    else if (zero_q) ts_w = {PW{1'b1}};
    else             ts_w = add_sat(narrow_sat(quo_w), add_q);
    trig_w = sub_floor(ts_w, PW'({ofs_q, 2'b00}));
  end

  logic dcm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      vin_q    <= '0;
      vbus_q   <= '0;
      vmin_q   <= '0;
      tnom_q   <= '0;
      tres_q   <= '0;
      ofs_q    <= '0;
      en_q     <= 1'b0;
      add_q    <= '0;
      zero_q   <= 1'b0;
      dcm_q    <= 1'b0;
      ts_out   <= '0;
      trig_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          vin_q  <= vin;
          vbus_q <= vbus;
          vmin_q <= vin_min;
          tnom_q <= t_nom;
          tres_q <= t_res;
          ofs_q  <= trig_ofs;
          en_q   <= pred_en;
          state  <= ST_PREP;
        end
        ST_PREP: begin
          add_q  <= add_w;
          zero_q <= den_zero_w;
          dcm_q  <= dcm_w;
          state  <= ST_DIV;
        end
        ST_DIV: if (div_last) state <= ST_FIN;
        ST_FIN: begin
          ts_out   <= ts_w;
          trig_out <= trig_w;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pfc_period_chk.sv
module pfc_period_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fin_w,
  input logic          div_zero_w,
  input logic          en_q,
  input logic [PW-1:0] ts_out,
  input logic [PW-1:0] trig_out
);
  // R10: result strobe lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: results move only on the finishing edge
  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_w |=> ($stable(ts_out) && $stable(trig_out)));

  // R10: leaving busy coincides with the done strobe
  a_r10_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: zero divisor yields the full-scale period
  a_r8_zero_div_max: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_w && div_zero_w && en_q) |=> (ts_out == {PW{1'b1}}));

  // R9: trigger never exceeds the period it was derived from
  a_r9_trig_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trig_out <= ts_out));
endmodule

bind pfc_resonant_period pfc_period_chk #(.PW(PW)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fin_w(fin_w),
  .div_zero_w(div_zero_w), .en_q(en_q), .ts_out(ts_out), .trig_out(trig_out)
);

// File: tb/test_pfc_resonant_period.sv
`timescale 1ns/1ps
module test_pfc_resonant_period;
  localparam int LAT = 46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, pred_en = 1'b0;
  logic [11:0] vin = '0, vbus = '0, vin_min = '0;
  logic [15:0] duty = '0, t_nom = '0, t_res = '0;
  logic [7:0]  trig_ofs = '0;
  logic [15:0] ts_out, trig_out;
  logic        done, busy;

  always #2.5 clk = ~clk;

  pfc_resonant_period i_pfc_resonant_period (
    .clk(clk), .rst_n(rst_n), .start(start), .pred_en(pred_en), .vin(vin),
    .vbus(vbus), .vin_min(vin_min), .duty(duty), .t_nom(t_nom), .t_res(t_res),
    .trig_ofs(trig_ofs), .ts_out(ts_out), .trig_out(trig_out), .done(done), .busy(busy)
  );

  int tests = 0, fails = 0, done_seen = 0;
  longint y_model = 0;
  logic [15:0] q_ts[$], q_trig[$];
  string q_tag[$];

  task automatic chk(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint lmin(longint a, longint b); return (a < b) ? a : b; endfunction

  // expected period, restated from the requirements
  function automatic longint model_ts(bit en, longint vi, longint vb, longint vm,
                                      longint tn, longint tr);
    longint ton, vo, dv, vc, den;
    if (!en) return tn;
    ton = lmin(((y_model / 256) * (tn / 16)) / 8192, 65535);
    vo  = lmin((vb * 40000) / 32768, 4095);
    dv  = (vo > vi) ? vo - vi : 0;
    if (vi < vo / 2) begin
      vc  = (vi < vm) ? vm : vi;
      den = 8 * vc * dv;
      if (den == 0) return 65535;
      return lmin(lmin((8*vc*ton*vo + tr*vo*dv) / den, 65535) + tr / 4, 65535);
    end
    if (dv == 0) return 65535;
    return lmin(lmin((ton * vo) / dv, 65535) + tr / 2, 65535);
  endfunction

  task automatic set_in(bit en, int vi, int vb, int vm, int du, int tn, int tr, int of);
    pred_en = en; vin = 12'(vi); vbus = 12'(vb); vin_min = 12'(vm);
    duty = 16'(du); t_nom = 16'(tn); t_res = 16'(tr); trig_ofs = 8'(of);
  endtask

  task automatic push_exp(string tag, bit en, int vi, int vb, int vm, int du, int tn, int tr, int of);
    longint ts, tg;
    y_model = y_model + du - (y_model / 4);
    ts = model_ts(en, vi, vb, vm, tn, tr);
    tg = (ts >= 4*of) ? ts - 4*of : 0;
    q_ts.push_back(16'(ts)); q_trig.push_back(16'(tg)); q_tag.push_back(tag);
  endtask

  task automatic run_job(string tag, bit en, int vi, int vb, int vm, int du, int tn, int tr, int of);
    int lat;
    @(negedge clk);
    set_in(en, vi, vb, vm, du, tn, tr, of);
    push_exp(tag, en, vi, vb, vm, du, tn, tr, of);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done) begin @(negedge clk); lat++; end
    chk({"R10 latency ", tag}, lat, LAT);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_seen++;
      if (q_ts.size() == 0) begin
        chk("R11 unexpected done", 1, 0);
      end else begin
        string tg;
        tg = q_tag.pop_front();
        chk({tg, " ts"}, ts_out, q_ts.pop_front());
        chk({tg, " trig"}, trig_out, q_trig.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    chk("R1 ts_out", ts_out, 0);
    chk("R1 trig_out", trig_out, 0);
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_job("R5 zero-voltage", 1, 300, 2000, 50, 40000, 60000, 800, 20);
    run_job("R2 filter grows", 1, 300, 2000, 50, 40000, 60000, 800, 20);
    run_job("R3 ontime", 1, 250, 1800, 20, 65535, 65535, 1200, 10);
    run_job("R6 clamp", 1, 10, 2000, 200, 40000, 60000, 800, 20);
    run_job("R7 valley", 1, 1500, 2000, 50, 40000, 60000, 800, 20);
    run_job("R5 below half", 1, 609, 1000, 0, 30000, 50000, 640, 5);
    run_job("R7 at half", 1, 610, 1000, 0, 30000, 50000, 640, 5);
    run_job("R8 valley zero dv", 1, 2500, 2000, 50, 40000, 60000, 800, 20);
    run_job("R8 zv zero vin", 1, 0, 2000, 0, 40000, 60000, 800, 20);
    run_job("R7 quotient sat", 1, 2440, 2000, 0, 40000, 60000, 800, 15);
    run_job("R4 bus sat", 1, 100, 4095, 10, 20000, 60000, 900, 3);
    run_job("R9 disabled", 0, 300, 2000, 50, 40000, 5000, 800, 30);
    run_job("R9 trig floor", 0, 300, 2000, 50, 40000, 100, 800, 200);

    // R11: second start while busy must be ignored
    @(negedge clk);
    set_in(1, 400, 2200, 30, 25000, 55000, 700, 12);
    push_exp("R11 first job kept", 1, 400, 2200, 30, 25000, 55000, 700, 12);
    d0 = done_seen;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 busy mid-job", busy, 1);
    set_in(1, 1800, 3000, 500, 9000, 20000, 3000, 60);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT + 20) @(negedge clk);
    chk("R11 single done", done_seen - d0, 1);
    run_job("R11 filter untouched", 1, 400, 2200, 30, 25000, 55000, 700, 12);

    chk("R10 queue drained", q_ts.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule